// File: doc/BRIEF.md
# Byte-Wide Configuration Register Slave on a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (clock plus open-drain data) read and write a small file of 32 byte-wide configuration registers. The bus clock and data lines are oversampled by a faster system clock. Start and stop conditions and both clock edges are recognised in that clock domain. The data line is modelled as a sampled input plus a drive-low enable, and the pad's pull-up is assumed outside the block.

The slave answers to one hardwired 7-bit device address. Each write transfers exactly one register. A read either names the register first, using a repeated start, or skips the register byte and returns the register at the address latched most recently. The low registers hold fixed identity values and cannot be written. The upper registers are writable and appear on a flat output vector for the surrounding logic to use. An active-low power-down input returns everything to its default values.

Top module: `cfg_twi_slave`

## Requirements
- R1: The slave responds only to device address 7'b0111111 (0x3F), sent as the upper seven bits of the first byte after a start, with the lowest bit selecting the direction (0 = write, 1 = read). For any other device address it acknowledges no byte until the next start, and neither a register nor the latched address changes.
- R2: A write is a start, the device address with direction 0, a register-address byte and a data byte. The slave acknowledges each of the three bytes by holding the data line low during the ninth clock. The writable registers 0x14 to 0x1F take the data byte, and register n is visible at regs_o[8n+7:8n].
- R3: A random read is a start, the device address with direction 0, the register address, a repeated start and the device address with direction 1. All three bytes are acknowledged and the slave then returns the current value of the addressed register.
- R4: A read made of the device address with direction 1 alone returns the register at the address latched by the register-address byte of the most recent addressed transaction.
- R5: Bytes are shifted most-significant bit first in both directions. The slave changes or releases the data line only while the bus clock is low.
- R6: After a read byte the slave accepts either an acknowledge or a not-acknowledge from the host. It keeps the data line released from then until the next start, and later transactions work normally.
- R7: After power-down the identity registers 0x00 to 0x06 read 0x05, 0x13, 0x27, 0x67, 0x00, 0x08, 0x87. Registers 0x07 to 0x0B read 0x00, and the writable registers 0x14 to 0x1F read 0x00.
- R8: Writes to 0x00 to 0x13 and to any address of 0x20 or above are acknowledged but change nothing. Reads of 0x0C to 0x13 and of 0x20 or above return 0x00.
- R9: While pwrdn_n is low, every register returns to its default, the latched address returns to 0x00, the data line is released and any transfer in progress is abandoned.
- R10: A write carries exactly one data byte. A further byte before the stop is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus lines |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous reset to defaults |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| regs_o | output | 256 | All 32 registers, register n at bits [8n+7:8n] |

## Verification
A wrong protocol state shows at the pads within the next byte: an acknowledge goes missing or appears where none is due, or read data is driven during the wrong clock. A register corrupted by a write that should have been ignored appears on regs_o a few system cycles after the ninth clock of that byte. A stale or damaged latched address shows on the very next short read as data from a different register. Each of these is seen long before the transaction after it ends.

// File: rtl/cfg_twi_pkg.sv
package cfg_twi_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-2:0] DEV_ADDR = 7'b0111111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ACK_DW,
        ST_ACK_DR,
        ST_REGADR,
        ST_ACK_REG,
        ST_WDATA,
        ST_ACK_WD,
        ST_RDATA,
        ST_MACK
    } twi_st_e;

    // Fixed contents of the identity and reserved read-only registers.
    function automatic logic [BYTE_W-1:0] fixed_value(input int unsigned idx);
        case (idx)
            0:       return 8'h05;
            1:       return 8'h13;
            2:       return 8'h27;
            3:       return 8'h67;
            5:       return 8'h08;
            6:       return 8'h87;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import cfg_twi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned S = SYNC_STAGES;

    typedef struct packed {
        logic [S:0] scl;
        logic [S:0] sda;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[S-1:0], scl_i};
        d.sda = {q.sda[S-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    // Bit S-1 is the settled sample, bit S the one before it.
    assign sda_s     = q.sda[S-1];
    assign scl_rise  = q.scl[S-1] & ~q.scl[S];
    assign scl_fall  = ~q.scl[S-1] & q.scl[S];
    assign start_det = q.scl[S-1] & q.scl[S] & q.sda[S] & ~q.sda[S-1];
    assign stop_det  = q.scl[S-1] & q.scl[S] & ~q.sda[S] & q.sda[S-1];

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
    import cfg_twi_pkg::*;
#(
    parameter logic [BYTE_W-2:0] DEV_ID = DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              sda_oe_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    typedef struct packed {
        twi_st_e           state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              wr;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (start_det) begin
            d.state = ST_DEVADR;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else if (stop_det) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                ST_DEVADR, ST_REGADR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = CNT_W'(q.cnt + 1'b1);
                    end else if (scl_fall && q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.state == ST_DEVADR) begin
                            if (q.shreg[BYTE_W-1:1] == DEV_ID) begin
                                d.oe    = 1'b1;
                                d.state = q.shreg[0] ? ST_ACK_DR : ST_ACK_DW;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else if (q.state == ST_REGADR) begin
                            d.ptr   = q.shreg;
                            d.oe    = 1'b1;
                            d.state = ST_ACK_REG;
                        end else begin
                            d.wr    = 1'b1;
                            d.oe    = 1'b1;
                            d.state = ST_ACK_WD;
                        end
                    end
                end
                ST_ACK_DW: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.state = ST_REGADR;
                    end
                end
                ST_ACK_REG: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.state = ST_WDATA;
                    end
                end
                ST_ACK_WD: begin
                    if (scl_fall) begin
                        d.oe    = 1'b0;
                        d.state = ST_IDLE;
                    end
                end
                ST_ACK_DR: begin
                    if (scl_fall) begin
                        d.shreg = rd_data;
                        d.oe    = ~rd_data[BYTE_W-1];
                        d.cnt   = '0;
                        d.state = ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = CNT_W'(q.cnt + 1'b1);
                    end else if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = ST_MACK;
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_fall) begin
                        d.state = ST_IDLE;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ST_IDLE, '0, '0, '0, 1'b0, 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign wr_en_o   = q.wr;
    assign wr_data_o = q.shreg;
    assign sda_oe_o  = q.oe;

    // R3 bit counter never passes one byte
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);

    // R5 the line is only pulled low right after a detected clock fall
    a_r5_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(scl_fall));

    // R6 line stays released in the host acknowledge slot
    a_r6_free_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_MACK) |-> !q.oe);

    // R10 one write strobe per data byte
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfg_twi_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned RW_FIRST = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int unsigned RW_COUNT = NUM_REGS - RW_FIRST;
    localparam int unsigned IW       = $clog2(NUM_REGS);

    logic [BYTE_W-1:0] rw_d [RW_COUNT];
    logic [BYTE_W-1:0] rw_q [RW_COUNT];
    logic [BYTE_W-1:0] view [NUM_REGS];
    logic              wr_hit;
    logic [IW-1:0]     wr_idx;

    assign wr_idx = wr_addr[IW-1:0];
    assign wr_hit = wr_en
                 && (wr_addr >= BYTE_W'(RW_FIRST))
                 && (wr_addr <  BYTE_W'(NUM_REGS));

    always_comb begin
        for (int i = 0; i < RW_COUNT; i++) begin
            rw_d[i] = rw_q[i];
            if (wr_hit && wr_addr == BYTE_W'(RW_FIRST + i)) begin
                rw_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RW_COUNT; i++) begin
                rw_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < RW_COUNT; i++) begin
                rw_q[i] <= rw_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        if (g >= RW_FIRST) begin : g_rw
            assign view[g] = rw_q[g - RW_FIRST];
        end else begin : g_ro
            assign view[g] = fixed_value(g);
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = view[g];
    end

    assign rd_data = (rd_addr < BYTE_W'(NUM_REGS)) ? view[rd_addr[IW-1:0]] : '0;

    // R2 an accepted write shows up on the output vector next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (regs_o[32'($past(wr_idx)) * BYTE_W +: BYTE_W] == $past(wr_data)));

    // R8 a write outside the writable window leaves every register alone
    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit) |=> $stable(regs_o));

endmodule

// File: rtl/cfg_twi_slave.sv
module cfg_twi_slave
    import cfg_twi_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 32,
    parameter int unsigned RW_FIRST    = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       pwrdn_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;

    twi_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (pwrdn_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_proto_fsm #(
        .DEV_ID(DEV_ADDR)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (pwrdn_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    cfg_reg_file #(
        .NUM_REGS(NUM_REGS),
        .RW_FIRST(RW_FIRST)
    ) i_regs (
        .clk     (clk),
        .rst_n   (pwrdn_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: tb/test_cfg_twi_slave.sv
module test_cfg_twi_slave;

    localparam int NR         = 32;
    localparam int QTR        = 5;
    localparam int WD_CYCLES  = 190000;
    localparam logic [6:0] DEV = 7'h3F;

    logic            clk = 1'b0;
    logic            pwrdn_n = 1'b0;
    logic            m_scl = 1'b1;
    logic            m_sda = 1'b1;
    logic            sda_line;
    logic            sda_oe_o;
    logic [NR*8-1:0] regs_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  exp_mem [NR];
    logic [7:0]  exp_ptr;
    logic [7:0]  v;
    logic [2:0]  acks;
    logic        a1;
    int unsigned rop;
    logic [7:0]  rra;
    logic [7:0]  rdat;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe_o;

    cfg_twi_slave i_cfg_twi_slave (
        .clk      (clk),
        .pwrdn_n  (pwrdn_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe_o),
        .regs_o   (regs_o)
    );

    // ---------------- expected model ----------------
    function automatic logic [7:0] id_val(input int a);
        case (a)
            0: return 8'h05;  1: return 8'h13;  2: return 8'h27;
            3: return 8'h67;  5: return 8'h08;  6: return 8'h87;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        return (a < 8'd32) ? exp_mem[a[4:0]] : 8'h00;
    endfunction

    function automatic logic [NR*8-1:0] exp_flat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = exp_mem[i];
        return f;
    endfunction

    task automatic reset_model();
        for (int i = 0; i < NR; i++) exp_mem[i] = id_val(i);
        exp_ptr = 8'h00;
    endtask

    task automatic model_write(input logic [7:0] ra, input logic [7:0] dat);
        exp_ptr = ra;
        if (ra >= 8'd20 && ra < 8'd32) exp_mem[ra[4:0]] = dat;
    endtask

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req, input string what);
        checks++;
        if (regs_o !== exp_flat()) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, regs_o, exp_flat());
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ---------------- bus master ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        m_sda = 1'b0; tick(QTR);
        m_scl = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        m_sda = 1'b1; tick(QTR);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(QTR);
            m_scl = 1'b1; tick(2*QTR);
            m_scl = 1'b0; tick(QTR);
        end
        m_sda = 1'b1; tick(QTR);
        m_scl = 1'b1; tick(QTR);
        acked = ~sda_line; tick(QTR);
        m_scl = 1'b0; tick(QTR);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        logic [7:0] t;
        t = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            tick(QTR);
            m_scl = 1'b1; tick(QTR);
            t[i] = sda_line; tick(QTR);
            m_scl = 1'b0; tick(QTR);
        end
        m_sda = nack; tick(QTR);
        m_scl = 1'b1; tick(2*QTR);
        m_scl = 1'b0; tick(QTR);
        b = t;
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] ra,
                          input logic [7:0] dat, output logic [2:0] ak);
        bus_start();
        put_byte({dev, 1'b0}, ak[2]);
        put_byte(ra, ak[1]);
        put_byte(dat, ak[0]);
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] ra, input logic nack,
                          output logic [7:0] b, output logic [2:0] ak);
        bus_start();
        put_byte({DEV, 1'b0}, ak[2]);
        put_byte(ra, ak[1]);
        bus_start();
        put_byte({DEV, 1'b1}, ak[0]);
        get_byte(nack, b);
        bus_stop();
    endtask

    task automatic short_rd(output logic [7:0] b, output logic ak);
        bus_start();
        put_byte({DEV, 1'b1}, ak);
        get_byte(1'b1, b);
        bus_stop();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h1C2B));
        reset_model();
        tick(5);
        pwrdn_n = 1'b1;
        tick(5);

        // reset state
        chk("R7", "data line released after reset", 32'(sda_oe_o), 0);
        chk_regs("R7", "register vector after reset");

        // sweep every register plus out-of-range addresses
        for (int a = 0; a < 34; a++) begin
            logic [7:0] ra;
            ra = (a == 32) ? 8'h20 : (a == 33) ? 8'hFF : 8'(a);
            rd_txn(ra, 1'b1, v, acks);
            exp_ptr = ra;
            chk("R3", "random read acks", 32'(acks), 32'h7);
            if (ra < 8'd12)      chk("R7", "default read value", 32'(v), 32'(exp_read(ra)));
            else if (ra < 8'd20) chk("R8", "unimplemented read", 32'(v), 32'(exp_read(ra)));
            else if (ra < 8'd32) chk("R7", "writable reset value", 32'(v), 32'(exp_read(ra)));
            else                 chk("R8", "out-of-range read", 32'(v), 32'h0);
        end

        // bit order, both directions
        wr_txn(DEV, 8'h14, 8'h01, acks);
        model_write(8'h14, 8'h01);
        chk("R5", "msb-first write of 0x01", 32'(regs_o[20*8 +: 8]), 32'h01);
        wr_txn(DEV, 8'h1F, 8'h80, acks);
        model_write(8'h1F, 8'h80);
        chk("R5", "msb-first write of 0x80", 32'(regs_o[31*8 +: 8]), 32'h80);
        rd_txn(8'h14, 1'b1, v, acks);
        exp_ptr = 8'h14;
        chk("R5", "msb-first read of 0x01", 32'(v), 32'h01);

        // all writable registers
        for (int a = 20; a < 32; a++) begin
            rdat = 8'($urandom);
            wr_txn(DEV, 8'(a), rdat, acks);
            model_write(8'(a), rdat);
            chk("R2", "write acks", 32'(acks), 32'h7);
            chk("R2", "written register on regs_o", 32'(regs_o[a*8 +: 8]), 32'(rdat));
        end
        chk_regs("R2", "vector after writable sweep");

        // short read after random read and after write
        rd_txn(8'h02, 1'b1, v, acks);
        exp_ptr = 8'h02;
        short_rd(v, a1);
        chk("R4", "short read ack", 32'(a1), 1);
        chk("R4", "short read after random read", 32'(v), 32'h27);
        wr_txn(DEV, 8'h18, 8'h5A, acks);
        model_write(8'h18, 8'h5A);
        short_rd(v, a1);
        chk("R4", "short read after write", 32'(v), 32'h5A);

        // writes that must be ignored
        wr_txn(DEV, 8'h03, 8'hFF, acks);
        model_write(8'h03, 8'hFF);
        chk("R8", "read-only write acks", 32'(acks), 32'h7);
        wr_txn(DEV, 8'h10, 8'h55, acks);
        model_write(8'h10, 8'h55);
        wr_txn(DEV, 8'h25, 8'h11, acks);
        model_write(8'h25, 8'h11);
        chk("R8", "out-of-range write acks", 32'(acks), 32'h7);
        chk_regs("R8", "vector after ignored writes");
        rd_txn(8'h03, 1'b1, v, acks);
        exp_ptr = 8'h03;
        chk("R8", "identity value kept", 32'(v), 32'h67);
        rd_txn(8'h10, 1'b1, v, acks);
        exp_ptr = 8'h10;
        chk("R8", "unimplemented stays zero", 32'(v), 32'h00);

        // foreign device addresses
        rd_txn(8'h1A, 1'b1, v, acks);
        exp_ptr = 8'h1A;
        wr_txn(7'h3E, 8'h1B, 8'hEE, acks);
        chk("R1", "address 0x3E acks", 32'(acks), 32'h0);
        wr_txn(7'h7F, 8'h1C, 8'hEE, acks);
        chk("R1", "address 0x7F acks", 32'(acks), 32'h0);
        bus_start();
        put_byte({7'h1F, 1'b1}, a1);
        bus_stop();
        chk("R1", "foreign read address ack", 32'(a1), 0);
        chk_regs("R1", "vector after foreign traffic");
        short_rd(v, a1);
        chk("R1", "latched address kept", 32'(v), 32'(exp_mem[26]));

        // host acknowledge at end of read, then release
        bus_start();
        put_byte({DEV, 1'b0}, a1);
        put_byte(8'h01, a1);
        bus_start();
        put_byte({DEV, 1'b1}, a1);
        get_byte(1'b0, v);
        exp_ptr = 8'h01;
        chk("R6", "read data with host ack", 32'(v), 32'h13);
        chk("R6", "line released after host ack", 32'(sda_oe_o), 0);
        bus_stop();
        chk("R6", "line released after stop", 32'(sda_oe_o), 0);
        rd_txn(8'h06, 1'b1, v, acks);
        exp_ptr = 8'h06;
        chk("R6", "next read works", 32'(v), 32'h87);

        // extra data byte in a write
        bus_start();
        put_byte({DEV, 1'b0}, a1);
        put_byte(8'h16, a1);
        put_byte(8'h3C, a1);
        model_write(8'h16, 8'h3C);
        put_byte(8'hC3, a1);
        bus_stop();
        chk("R10", "extra byte not acked", 32'(a1), 0);
        chk("R10", "register keeps first byte", 32'(regs_o[22*8 +: 8]), 32'h3C);

        // mixed random traffic
        for (int n = 0; n < 40; n++) begin
            rop  = $urandom % 3;
            rra  = 8'($urandom % 40);
            rdat = 8'($urandom);
            if (rop == 0) begin
                wr_txn(DEV, rra, rdat, acks);
                model_write(rra, rdat);
                chk("R2", "random write acks", 32'(acks), 32'h7);
                chk_regs("R2", "vector after random write");
            end else if (rop == 1) begin
                rd_txn(rra, 1'(n % 2), v, acks);
                exp_ptr = rra;
                chk("R3", "random read value", 32'(v), 32'(exp_read(rra)));
            end else begin
                short_rd(v, a1);
                chk("R4", "random short read value", 32'(v), 32'(exp_read(exp_ptr)));
            end
        end

        // power-down in the middle of a write
        bus_start();
        put_byte({DEV, 1'b0}, a1);
        put_byte(8'h15, a1);
        m_sda = 1'b0; tick(QTR);
        pwrdn_n = 1'b0;
        m_scl = 1'b1; m_sda = 1'b1;
        tick(4);
        reset_model();
        chk("R9", "line released in power-down", 32'(sda_oe_o), 0);
        chk_regs("R9", "defaults in power-down");
        pwrdn_n = 1'b1;
        tick(4);
        short_rd(v, a1);
        chk("R9", "latched address back to 0x00", 32'(v), 32'h05);
        rd_txn(8'h15, 1'b1, v, acks);
        chk("R9", "writable register cleared", 32'(v), 32'h00);

        report();
    end

endmodule